// File: doc/BRIEF.md
# Bus-Activity Watchdog and Reset Generator

This block guards a system by watching the chip-select line of a serial bus. Every qualified falling edge of chip-select counts as proof of life and restarts a timeout counter. If chip-select stays at one level for longer than the selected period, whether parked high or stuck low, the block raises a system reset for a fixed hold time. A two-bit period setting chooses between a long, a medium and a short timeout, or switches the watchdog off.

The same reset output also serves a supply monitor. A digital supply-good input, driven by an external detector, forces reset while it is low. Reset is only released after the supply has been good without interruption for the hold time. The same hold applies after the asynchronous power-on reset. All periods are counted in ticks of a parameterised prescaler running from the system clock. The polarity of the output is a build parameter.

Top module: `bus_wdog`

## Requirements
- R1: After rst_ni is released with supply_ok_i high, the reset output stays active for HOLD_TICKS*TICK_DIV clocks (within a few clocks of latency) and is then released. It is active while rst_ni is low.
- R2: While supply_ok_i is low, the reset output is active from the next clock edge onward.
- R3: After supply_ok_i returns high, reset is released only once supply_ok_i has been high for HOLD_TICKS*TICK_DIV consecutive clocks. A dip during that wait restarts the wait.
- R4: period_sel_i selects the timeout: 2'b00 gives LONG_TICKS, 2'b01 gives MID_TICKS and 2'b10 gives SHORT_TICKS, each multiplied by TICK_DIV clocks. 2'b11 disables the watchdog, so it never trips.
- R5: A chip-select low level seen for at least MIN_LOW_CLKS clocks after the two-stage synchroniser restarts the timeout count.
- R6: A chip-select low pulse shorter than MIN_LOW_CLKS clocks has no effect on the timeout.
- R7: The watchdog trips when chip-select is held high, and also when it is held low, for longer than the selected timeout.
- R8: A watchdog trip keeps reset active for HOLD_TICKS*TICK_DIV clocks. After release the timeout count starts again from zero, so no trip can follow at once.
- R9: Any change of period_sel_i restarts the timeout count under the new period.
- R10: With ACTIVE_HIGH=1 a high output means reset; with ACTIVE_HIGH=0 a low output means reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| cs_i | input | 1 | Monitored bus chip-select, asynchronous to clk_i |
| supply_ok_i | input | 1 | Supply-good indication, low forces reset |
| period_sel_i | input | 2 | Timeout selection, held externally and not cleared by any reset |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |

## Verification
The two sources of reset, a watchdog expiry and a supply drop, can fall on the same clock. The bench provokes this by pulling supply-good low two clocks before a known watchdog deadline and keeping it low past that deadline. It then checks that reset is still held at the point where a watchdog-only hold would already have ended, and that release follows exactly one full hold time after the supply comes back.

// File: rtl/bus_wdog_pkg.sv
package bus_wdog_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/wd_cs_qualifier.sv
module wd_cs_qualifier #(
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned MIN_LOW  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic kick_o
);
  localparam int unsigned LW = $clog2(MIN_LOW + 1);

  logic [SYNC_N-1:0] sync_q;
  logic [LW-1:0]     low_q;
  logic              cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], cs_i};
  end

  assign cs_s = sync_q[SYNC_N-1];

  // length of the current low run, saturating once qualified
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   low_q <= '0;
    else if (cs_s)                 low_q <= '0;
    else if (low_q != LW'(MIN_LOW)) low_q <= low_q + 1'b1;
  end

  assign kick_o = !cs_s && (low_q == LW'(MIN_LOW - 1));
endmodule

// File: rtl/wd_tick_timer.sv
module wd_tick_timer #(
  parameter int unsigned DIV   = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick      = (pre_q == PRE_W'(DIV - 1));
  assign expired_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!expired_o) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_wdog.sv
module bus_wdog
  import bus_wdog_pkg::*;
#(
  parameter bit          ACTIVE_HIGH  = 1'b0,
  parameter int unsigned TICK_DIV     = 8,
  parameter int unsigned LONG_TICKS   = 28,
  parameter int unsigned MID_TICKS    = 12,
  parameter int unsigned SHORT_TICKS  = 4,
  parameter int unsigned HOLD_TICKS   = 4,
  parameter int unsigned MIN_LOW_CLKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       supply_ok_i,
  input  logic [1:0] period_sel_i,
  output logic       sys_rst_o
);
  localparam int unsigned MAX_A = (LONG_TICKS > MID_TICKS) ? LONG_TICKS : MID_TICKS;
  localparam int unsigned MAX_B = (SHORT_TICKS > HOLD_TICKS) ? SHORT_TICKS : HOLD_TICKS;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  wd_sel_e          sel, sel_q;
  logic [CNT_W-1:0] wd_limit;
  logic             kick, sel_chg, wd_off;
  logic             wd_clr, wd_exp, wd_trip;
  logic             hold_clr, hold_exp;
  logic             rst_act_q;

  assign sel = wd_sel_e'(period_sel_i);

  wd_cs_qualifier #(.SYNC_N(2), .MIN_LOW(MIN_LOW_CLKS)) i_cs_qual (
    .clk_i, .rst_ni, .cs_i, .kick_o(kick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= WD_OFF;
    else         sel_q <= sel;
  end

  assign sel_chg = (sel != sel_q);
  assign wd_off  = (sel == WD_OFF);

  always_comb begin
    case (sel)
      WD_LONG:  wd_limit = CNT_W'(LONG_TICKS);
      WD_MID:   wd_limit = CNT_W'(MID_TICKS);
      WD_SHORT: wd_limit = CNT_W'(SHORT_TICKS);
      default:  wd_limit = '1;
    endcase
  end

  assign wd_clr = kick | sel_chg | wd_off | rst_act_q;

  wd_tick_timer #(.DIV(TICK_DIV), .CNT_W(CNT_W)) i_wd_timer (
    .clk_i, .rst_ni, .clr_i(wd_clr), .limit_i(wd_limit), .expired_o(wd_exp)
  );

  assign wd_trip  = wd_exp & !wd_clr;
  assign hold_clr = !supply_ok_i | wd_trip | !rst_act_q;

  wd_tick_timer #(.DIV(TICK_DIV), .CNT_W(CNT_W)) i_hold_timer (
    .clk_i, .rst_ni, .clr_i(hold_clr), .limit_i(CNT_W'(HOLD_TICKS)), .expired_o(hold_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rst_act_q <= 1'b1;
    else if (!supply_ok_i || wd_trip) rst_act_q <= 1'b1;
    else if (hold_exp)              rst_act_q <= 1'b0;
  end

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign sys_rst_o = rst_act_q;
    end else begin : g_pol_lo
      assign sys_rst_o = !rst_act_q;
    end
  endgenerate
endmodule

// File: rtl/bus_wdog_chk.sv
module bus_wdog_chk #(
  parameter bit          ACTIVE_HIGH = 1'b0,
  parameter int unsigned HOLD_CLKS   = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic [1:0] period_sel_i,
  input logic       sys_rst_o
);
  logic        act;
  int unsigned hc_q;

  assign act = ACTIVE_HIGH ? sys_rst_o : !sys_rst_o;

  // clocks spent in reset with the supply good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hc_q <= 0;
    else if (!act || !supply_ok_i) hc_q <= 0;
    else if (hc_q != 32'hFFFF_FFFF) hc_q <= hc_q + 1;
  end

  a_r2_supply_low_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> act);

  a_r3_release_after_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act) |-> (hc_q >= HOLD_CLKS));

  a_r3_release_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act) |-> $past(supply_ok_i));

  a_r8_no_immediate_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(act) && supply_ok_i) |=> !act);

  a_r4_off_never_trips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_sel_i == 2'b11 && supply_ok_i && !act) |=> !act);
endmodule

bind bus_wdog bus_wdog_chk #(
  .ACTIVE_HIGH(ACTIVE_HIGH),
  .HOLD_CLKS(HOLD_TICKS * TICK_DIV)
) i_bus_wdog_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .supply_ok_i(supply_ok_i),
  .period_sel_i(period_sel_i),
  .sys_rst_o(sys_rst_o)
);

// File: tb/test_bus_wdog.sv
module test_bus_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 8;
  localparam int LONGT = 28;
  localparam int MIDT  = 12;
  localparam int SHRT  = 4;
  localparam int HOLD  = 4;
  localparam int MINL  = 4;
  localparam int HC    = HOLD * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b1;
  logic       sup = 1'b1;
  logic [1:0] sel = 2'b10;
  logic       rst_lo, rst_hi;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wdog #(.ACTIVE_HIGH(1'b0), .TICK_DIV(DIV), .LONG_TICKS(LONGT), .MID_TICKS(MIDT),
             .SHORT_TICKS(SHRT), .HOLD_TICKS(HOLD), .MIN_LOW_CLKS(MINL)) i_bus_wdog (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .supply_ok_i(sup),
    .period_sel_i(sel), .sys_rst_o(rst_lo));

  bus_wdog #(.ACTIVE_HIGH(1'b1), .TICK_DIV(DIV), .LONG_TICKS(LONGT), .MID_TICKS(MIDT),
             .SHORT_TICKS(SHRT), .HOLD_TICKS(HOLD), .MIN_LOW_CLKS(MINL)) i_bus_wdog_hi (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .supply_ok_i(sup),
    .period_sel_i(sel), .sys_rst_o(rst_hi));

  function automatic int ticks_of(logic [1:0] s);
    case (s)
      2'b00:   return LONGT;
      2'b01:   return MIDT;
      default: return SHRT;
    endcase
  endfunction

  // clocks from cs falling to visible trip: sync, qualify, count, register
  function automatic int dly(int t);
    return MINL + 3 + t * DIV;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic act, logic exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic expect_act(logic exp, string req);
    check(!rst_lo, exp, req);
    check(rst_hi, !rst_lo, "R10 polarity");
  endtask

  task automatic drive_low(int w);
    cs = 1'b0;
    step(w);
    cs = 1'b1;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 3000; i++) begin
      if (rst_lo === 1'b1) return;
      step(1);
    end
    check(1'b0, 1'b1, "R3 release never seen");
  endtask

  task automatic fresh(logic [1:0] s);
    sel = 2'b11;
    step(2);
    sel = s;
    wait_release();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d, t;
    step(3);
    expect_act(1'b1, "R1 reset state");
    rst_n = 1'b1;
    step(HC - 3); expect_act(1'b1, "R1 power-up hold");
    step(6);      expect_act(1'b0, "R1 power-up release");

    // R4 sweep over the three periods, stuck-high trips, hold and restart
    for (int k = 0; k < 3; k++) begin
      fresh(2'(k));
      t = ticks_of(2'(k)) * DIV;
      d = dly(ticks_of(2'(k)));
      drive_low(8);
      step(d - 11); expect_act(1'b0, "R4 before deadline");
      step(6);      expect_act(1'b1, "R4 trip at period");
      step(HC - 6); expect_act(1'b1, "R8 hold after trip");
      step(7);      expect_act(1'b0, "R8 release after hold");
      step(t - 8);  expect_act(1'b0, "R8 count restarted from zero");
      step(9);      expect_act(1'b1, "R7 stuck high trips");
    end

    // R7 stuck low
    fresh(2'b10);
    d = dly(SHRT);
    cs = 1'b0;
    step(d - 3); expect_act(1'b0, "R7 before deadline low");
    step(6);     expect_act(1'b1, "R7 stuck low trips");
    cs = 1'b1;

    // R4 disabled
    fresh(2'b11);
    step(2 * LONGT * DIV + 50); expect_act(1'b0, "R4 off never trips");
    drive_low(8);
    step(300);                  expect_act(1'b0, "R4 off after activity");

    // R5 restart by a second kick
    fresh(2'b10);
    drive_low(8);
    step(12);
    drive_low(8);
    step(d + 3 - 28); expect_act(1'b0, "R5 kick restarted count");
    step(14);         expect_act(1'b0, "R5 before new deadline");
    step(6);          expect_act(1'b1, "R5 trip after new deadline");

    // R5 boundary: low for exactly MINL clocks qualifies
    fresh(2'b10);
    drive_low(8);
    step(12);
    drive_low(MINL);
    step(d + 3 - 24); expect_act(1'b0, "R5 minimum width accepted");
    step(20);         expect_act(1'b1, "R5 trip after min-width kick");

    // R6 short pulse ignored
    fresh(2'b10);
    drive_low(8);
    step(12);
    drive_low(MINL - 1);
    step(d - 3 - 23); expect_act(1'b0, "R6 before original deadline");
    step(6);          expect_act(1'b1, "R6 short pulse ignored");

    // R9 period change restarts the count
    fresh(2'b10);
    drive_low(8);
    step(12);
    sel = 2'b01;
    step(d + 3 - 20);  expect_act(1'b0, "R9 old deadline passed");
    step(71);          expect_act(1'b0, "R9 before new deadline");
    step(7);           expect_act(1'b1, "R9 trip at new period");

    // R2 / R3 supply monitor
    fresh(2'b11);
    sup = 1'b0;
    step(2);      expect_act(1'b1, "R2 supply low forces reset");
    step(8);      expect_act(1'b1, "R2 held while low");
    sup = 1'b1;
    step(HC - 3); expect_act(1'b1, "R3 hold after recovery");
    step(6);      expect_act(1'b0, "R3 release after recovery");
    sup = 1'b0;
    step(4);
    sup = 1'b1;
    step(16);
    sup = 1'b0;
    step(3);
    sup = 1'b1;
    step(HC - 16); expect_act(1'b1, "R3 dip restarts hold");
    step(19);      expect_act(1'b0, "R3 release after dip");

    // supply drop coinciding with a watchdog trip
    fresh(2'b10);
    drive_low(8);
    step(d - 10);
    sup = 1'b0;
    step(20);
    sup = 1'b1;
    step(HC - 14); expect_act(1'b1, "R2 supply outlasts trip hold");
    step(17);      expect_act(1'b0, "R3 release after shared event");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule